// File: doc/BRIEF.md
# Rename-Stage Move and Idiom Eliminator

This block sits in front of a register alias table. Each cycle it takes a group of up to five decoded micro-ops and sorts each one into one of four classes:

- a register copy that can be removed,
- a zeroing idiom,
- a ones idiom,
- an ordinary operation that must execute.

It keeps a small map from 16 architectural registers to physical tags. Physical tag 0 is reserved as a register that always holds zero.

Each class updates the map in its own way:

- An ordinary operation, or a ones idiom, takes the fresh tag that an external allocator offers on its lane.
- A removed copy makes its destination share the physical tag of its source. It does not take a fresh tag.
- A zeroing idiom points its destination at tag 0.

Lanes are resolved strictly in order within a group. A later lane therefore sees the tag that an earlier lane in the same group produced. This makes chained copies collapse onto the original tag, and it lets the same register be renamed by all five lanes.

Results are registered: a group presented before a rising edge appears on the outputs after that edge, and the map is updated at the same edge. For each lane, the outputs give:

- an eliminated flag and a zero flag,
- the destination tag,
- both source tags,
- a ready-override bit per source, meaning the source carries no wait.

Top module: `move_elim`

## Requirements

- R1: While reset is active, every output is 0. After reset, architectural register r maps to physical tag r+1.
- R2: Lane results appear one clock after the group is presented.
  - Lanes are resolved in order 0 to 4. Every valid lane that is not eliminated writes the fresh tag of its own lane (`in_new_tag` bits [7l+6:7l]) into the map at its destination, and reports that tag as its destination tag.
  - If several lanes write the same register, the last one wins.
  - A lane with valid=0 reports out_valid=0 and changes nothing.
- R3: A plain copy (kind 1) is eliminated when all of the following hold:
  - source width code equals destination width code;
  - that width code is 32-bit (2), 64-bit (3), 128-bit vector (4) or 256-bit vector (5);
  - destination differs from the source.
  
  An eliminated copy reports out_elim=1, out_zero=0, and destination tag equal to its source tag. The destination register then shares that tag.
- R4: Chained copies within one group resolve to the original physical tag. A later lane reading the final destination sees that same tag.
- R5: A sign-extending copy (kind 3) is never eliminated. A zero-extending copy (kind 2) is eliminated only from an 8-bit source (width 0) into a 32-bit or 64-bit destination. A 16-bit source (width 1) is not eliminated.
- R6: A copy whose destination width is 8-bit (0) or 16-bit (1) is never eliminated.
- R7: A copy whose source register equals its destination register is never eliminated. It is renamed as an ordinary operation.
- R8: An XOR-type op (kind 4) with both sources equal to the destination, and a destination width of 32 bits or wider, is a zeroing idiom. It reports:
  - out_elim=1 and out_zero=1;
  - destination tag 0;
  - source tags 0, with both ready bits set.
  
  The register then maps to tag 0. With a narrower destination it is an ordinary operation.
- R9: A packed compare-equal (kind 5) with both sources equal to the destination is a ones idiom. It is not eliminated and takes its lane's fresh tag. It reports source tags 0 with both ready bits set.
- R10: While elim_disable is 1, no copy of any kind is eliminated. Zeroing idioms are still removed.
- R11: For non-idiom lanes, a source ready bit is 1 exactly when that source maps to tag 0. Plain op kind is 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elim_disable | input | 1 | Forces every copy to be renamed normally |
| in_valid | input | 5 | Lane valid bits |
| in_kind | input | 15 | Op kind per lane, 3 bits each (0 plain, 1 copy, 2 zero-extend, 3 sign-extend, 4 XOR-type, 5 compare-equal) |
| in_dst_width | input | 15 | Destination width code per lane (0 8b, 1 16b, 2 32b, 3 64b, 4 128b vector, 5 256b vector) |
| in_src_width | input | 15 | Source width code per lane, same encoding |
| in_dst | input | 20 | Destination architectural register per lane |
| in_src1 | input | 20 | First source architectural register per lane |
| in_src2 | input | 20 | Second source architectural register per lane |
| in_new_tag | input | 35 | Fresh physical tag offered to each lane |
| out_valid | output | 5 | Registered lane valid bits |
| out_elim | output | 5 | Lane removed from execution |
| out_zero | output | 5 | Lane was a zeroing idiom |
| out_dst_tag | output | 35 | Destination physical tag per lane |
| out_src1_tag | output | 35 | First source physical tag per lane |
| out_src2_tag | output | 35 | Second source physical tag per lane |
| out_src1_rdy | output | 5 | First source needs no wait |
| out_src2_rdy | output | 5 | Second source needs no wait |

## Verification

A table of single-lane ops runs through every width and extension combination. The table tells apart:

- copies that must be removed from those that must not: narrow destinations, mismatched widths, 16-bit zero-extension, sign-extension and self-copies;
- full-width zeroing idioms from narrow ones.

Multi-lane groups then check ordering effects:

- five writes to one register, to show that only the last is kept;
- a three-link copy chain, to show that aliasing is transitive within one cycle;
- a zeroing idiom followed by a reader and a copy, to show that tag 0 brings the ready override;
- an invalid lane, to show that it leaves the map untouched.

A group run with elimination disabled separates the copy path from the idiom path.

// File: rtl/elim_pkg.sv
package elim_pkg;

    localparam int KIND_W = 3;
    localparam int WID_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        K_PLAIN = 3'd0,
        K_COPY  = 3'd1,
        K_ZEXT  = 3'd2,
        K_SEXT  = 3'd3,
        K_XOR   = 3'd4,
        K_CMPEQ = 3'd5
    } kind_e;

    typedef enum logic [WID_W-1:0] {
        WD_B8   = 3'd0,
        WD_B16  = 3'd1,
        WD_B32  = 3'd2,
        WD_B64  = 3'd3,
        WD_V128 = 3'd4,
        WD_V256 = 3'd5
    } width_e;

    typedef enum logic [1:0] {
        CL_EXEC  = 2'd0,
        CL_ALIAS = 2'd1,
        CL_ZERO  = 2'd2,
        CL_ONES  = 2'd3
    } class_e;

    // Widths whose write replaces the whole physical register
    function automatic logic full_width(input logic [WID_W-1:0] w);
        return (w == WD_B32) || (w == WD_B64) || (w == WD_V128) || (w == WD_V256);
    endfunction

endpackage

// File: rtl/elim_classify.sv
module elim_classify
    import elim_pkg::*;
#(
    parameter int AREG_W = 4
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic [WID_W-1:0]  dwid_i,
    input  logic [WID_W-1:0]  swid_i,
    input  logic [AREG_W-1:0] dst_i,
    input  logic [AREG_W-1:0] src1_i,
    input  logic [AREG_W-1:0] src2_i,
    input  logic              no_elim_i,
    output logic [1:0]        cls_o
);

    class_e cls;
    logic   same_all;
    logic   not_self;

    always_comb begin
        same_all = (src1_i == dst_i) && (src2_i == dst_i);
        not_self = (src1_i != dst_i);
        cls      = CL_EXEC;
        case (kind_i)
            K_COPY: begin
                if (!no_elim_i && not_self && (dwid_i == swid_i) && full_width(dwid_i))
                    cls = CL_ALIAS;
            end
            K_ZEXT: begin
                if (!no_elim_i && not_self && (swid_i == WD_B8) &&
                    ((dwid_i == WD_B32) || (dwid_i == WD_B64)))
                    cls = CL_ALIAS;
            end
            K_XOR: begin
                if (same_all && full_width(dwid_i))
                    cls = CL_ZERO;
            end
            K_CMPEQ: begin
                if (same_all)
                    cls = CL_ONES;
            end
            default: cls = CL_EXEC;
        endcase
        cls_o = cls;
    end

endmodule

// File: rtl/elim_rename.sv
module elim_rename
    import elim_pkg::*;
#(
    parameter int LANES = 5,
    parameter int AREGS = 16,
    parameter int TAG_W = 7,
    localparam int AREG_W = $clog2(AREGS)
) (
    input  logic [AREGS-1:0][TAG_W-1:0]  map_i,
    input  logic [LANES-1:0]             valid_i,
    input  logic [LANES-1:0][1:0]        cls_i,
    input  logic [LANES-1:0][AREG_W-1:0] dst_i,
    input  logic [LANES-1:0][AREG_W-1:0] src1_i,
    input  logic [LANES-1:0][AREG_W-1:0] src2_i,
    input  logic [LANES-1:0][TAG_W-1:0]  new_tag_i,
    output logic [AREGS-1:0][TAG_W-1:0]  map_o,
    output logic [LANES-1:0][TAG_W-1:0]  dst_tag_o,
    output logic [LANES-1:0][TAG_W-1:0]  s1_tag_o,
    output logic [LANES-1:0][TAG_W-1:0]  s2_tag_o,
    output logic [LANES-1:0]             s1_rdy_o,
    output logic [LANES-1:0]             s2_rdy_o,
    output logic [LANES-1:0]             elim_o,
    output logic [LANES-1:0]             zero_o
);

    // Working copy of the map, updated lane by lane so later lanes see earlier writes
    logic [AREGS-1:0][TAG_W-1:0] work;
    logic [TAG_W-1:0]            a_tag;
    logic [TAG_W-1:0]            b_tag;

    always_comb begin
        work      = map_i;
        dst_tag_o = '0;
        s1_tag_o  = '0;
        s2_tag_o  = '0;
        s1_rdy_o  = '0;
        s2_rdy_o  = '0;
        elim_o    = '0;
        zero_o    = '0;
        a_tag     = '0;
        b_tag     = '0;
        for (int l = 0; l < LANES; l++) begin
            if (valid_i[l]) begin
                a_tag = work[src1_i[l]];
                b_tag = work[src2_i[l]];
                case (class_e'(cls_i[l]))
                    CL_ALIAS: begin
                        s1_tag_o[l]     = a_tag;
                        s2_tag_o[l]     = b_tag;
                        s1_rdy_o[l]     = (a_tag == '0);
                        s2_rdy_o[l]     = (b_tag == '0);
                        dst_tag_o[l]    = a_tag;
                        elim_o[l]       = 1'b1;
                        work[dst_i[l]]  = a_tag;
                    end
                    CL_ZERO: begin
                        s1_rdy_o[l]     = 1'b1;
                        s2_rdy_o[l]     = 1'b1;
                        dst_tag_o[l]    = '0;
                        elim_o[l]       = 1'b1;
                        zero_o[l]       = 1'b1;
                        work[dst_i[l]]  = '0;
                    end
                    CL_ONES: begin
                        s1_rdy_o[l]     = 1'b1;
                        s2_rdy_o[l]     = 1'b1;
                        dst_tag_o[l]    = new_tag_i[l];
                        work[dst_i[l]]  = new_tag_i[l];
                    end
                    default: begin
                        s1_tag_o[l]     = a_tag;
                        s2_tag_o[l]     = b_tag;
                        s1_rdy_o[l]     = (a_tag == '0);
                        s2_rdy_o[l]     = (b_tag == '0);
                        dst_tag_o[l]    = new_tag_i[l];
                        work[dst_i[l]]  = new_tag_i[l];
                    end
                endcase
            end
        end
        map_o = work;
    end

endmodule

// File: rtl/move_elim.sv
module move_elim
    import elim_pkg::*;
#(
    parameter int LANES = 5,
    parameter int AREGS = 16,
    parameter int TAG_W = 7,
    localparam int AREG_W = $clog2(AREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      elim_disable,
    input  logic [LANES-1:0]          in_valid,
    input  logic [LANES*KIND_W-1:0]   in_kind,
    input  logic [LANES*WID_W-1:0]    in_dst_width,
    input  logic [LANES*WID_W-1:0]    in_src_width,
    input  logic [LANES*AREG_W-1:0]   in_dst,
    input  logic [LANES*AREG_W-1:0]   in_src1,
    input  logic [LANES*AREG_W-1:0]   in_src2,
    input  logic [LANES*TAG_W-1:0]    in_new_tag,
    output logic [LANES-1:0]          out_valid,
    output logic [LANES-1:0]          out_elim,
    output logic [LANES-1:0]          out_zero,
    output logic [LANES*TAG_W-1:0]    out_dst_tag,
    output logic [LANES*TAG_W-1:0]    out_src1_tag,
    output logic [LANES*TAG_W-1:0]    out_src2_tag,
    output logic [LANES-1:0]          out_src1_rdy,
    output logic [LANES-1:0]          out_src2_rdy
);

    typedef struct packed {
        logic [AREGS-1:0][TAG_W-1:0] map;
        logic [LANES-1:0]            vld;
        logic [LANES-1:0]            elim;
        logic [LANES-1:0]            zero;
        logic [LANES-1:0]            r1;
        logic [LANES-1:0]            r2;
        logic [LANES-1:0][TAG_W-1:0] dt;
        logic [LANES-1:0][TAG_W-1:0] s1;
        logic [LANES-1:0][TAG_W-1:0] s2;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][KIND_W-1:0] kind_a;
    logic [LANES-1:0][WID_W-1:0]  dwid_a;
    logic [LANES-1:0][WID_W-1:0]  swid_a;
    logic [LANES-1:0][AREG_W-1:0] dst_a;
    logic [LANES-1:0][AREG_W-1:0] src1_a;
    logic [LANES-1:0][AREG_W-1:0] src2_a;
    logic [LANES-1:0][TAG_W-1:0]  tag_a;
    logic [LANES-1:0][1:0]        cls_a;

    assign kind_a = in_kind;
    assign dwid_a = in_dst_width;
    assign swid_a = in_src_width;
    assign dst_a  = in_dst;
    assign src1_a = in_src1;
    assign src2_a = in_src2;
    assign tag_a  = in_new_tag;

    for (genvar l = 0; l < LANES; l++) begin : g_cls
        elim_classify #(.AREG_W(AREG_W)) u_cls (
            .kind_i    (kind_a[l]),
            .dwid_i    (dwid_a[l]),
            .swid_i    (swid_a[l]),
            .dst_i     (dst_a[l]),
            .src1_i    (src1_a[l]),
            .src2_i    (src2_a[l]),
            .no_elim_i (elim_disable),
            .cls_o     (cls_a[l])
        );
    end

    logic [AREGS-1:0][TAG_W-1:0]  map_nx;
    logic [LANES-1:0][TAG_W-1:0]  dt_nx, s1_nx, s2_nx;
    logic [LANES-1:0]             r1_nx, r2_nx, elim_nx, zero_nx;

    elim_rename #(.LANES(LANES), .AREGS(AREGS), .TAG_W(TAG_W)) u_ren (
        .map_i     (st_q.map),
        .valid_i   (in_valid),
        .cls_i     (cls_a),
        .dst_i     (dst_a),
        .src1_i    (src1_a),
        .src2_i    (src2_a),
        .new_tag_i (tag_a),
        .map_o     (map_nx),
        .dst_tag_o (dt_nx),
        .s1_tag_o  (s1_nx),
        .s2_tag_o  (s2_nx),
        .s1_rdy_o  (r1_nx),
        .s2_rdy_o  (r2_nx),
        .elim_o    (elim_nx),
        .zero_o    (zero_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.map  = map_nx;
        st_d.vld  = in_valid;
        st_d.elim = elim_nx;
        st_d.zero = zero_nx;
        st_d.r1   = r1_nx;
        st_d.r2   = r2_nx;
        st_d.dt   = dt_nx;
        st_d.s1   = s1_nx;
        st_d.s2   = s2_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int r = 0; r < AREGS; r++)
                st_q.map[r] <= TAG_W'(r + 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign out_elim     = st_q.elim;
    assign out_zero     = st_q.zero;
    assign out_src1_rdy = st_q.r1;
    assign out_src2_rdy = st_q.r2;
    assign out_dst_tag  = st_q.dt;
    assign out_src1_tag = st_q.s1;
    assign out_src2_tag = st_q.s2;

    // R10
    copy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(elim_disable) |-> ((out_elim & ~out_zero) == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R8
        zero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && out_zero[l]) |->
            (out_dst_tag[l*TAG_W +: TAG_W] == '0) && out_elim[l] && out_src1_rdy[l] && out_src2_rdy[l]);
        // R3
        alias_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && out_elim[l] && !out_zero[l]) |->
            (out_dst_tag[l*TAG_W +: TAG_W] == out_src1_tag[l*TAG_W +: TAG_W]));
        // R2
        fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && !out_elim[l]) |->
            (out_dst_tag[l*TAG_W +: TAG_W] == $past(in_new_tag[l*TAG_W +: TAG_W])));
        // R7
        self_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid[l] && (in_kind[l*KIND_W +: KIND_W] == K_COPY) &&
                  (in_dst[l*AREG_W +: AREG_W] == in_src1[l*AREG_W +: AREG_W])) |-> !out_elim[l]);
        // R5
        sext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid[l] && (in_kind[l*KIND_W +: KIND_W] == K_SEXT)) |-> !out_elim[l]);
    end

endmodule

// File: tb/test_move_elim.sv
`timescale 1ns/1ps
module test_move_elim;

    localparam int LN = 5;
    localparam int AR = 16;
    localparam int TW = 7;

    localparam logic [2:0] KP = 3'd0, KC = 3'd1, KZ = 3'd2, KS = 3'd3, KX = 3'd4, KQ = 3'd5;
    localparam logic [2:0] B8 = 3'd0, B16 = 3'd1, B32 = 3'd2, B64 = 3'd3, V1 = 3'd4, V2 = 3'd5;

    typedef struct packed {
        logic [3:0] rq;
        logic [2:0] k;
        logic [2:0] dw;
        logic [2:0] sw;
        logic [3:0] d;
        logic [3:0] s;
        logic [1:0] cl;   // 0 exec, 1 alias, 2 zero idiom, 3 ones idiom
    } row_t;

    localparam int NROW = 17;
    localparam row_t ROWS [NROW] = '{
        '{4'd3, KC, B32, B32, 4'd1,  4'd2,  2'd1},  // R3 32-bit copy
        '{4'd3, KC, B64, B64, 4'd3,  4'd4,  2'd1},  // R3 64-bit copy
        '{4'd3, KC, V1,  V1,  4'd5,  4'd6,  2'd1},  // R3 128-bit vector
        '{4'd3, KC, V2,  V2,  4'd7,  4'd8,  2'd1},  // R3 256-bit vector
        '{4'd6, KC, B16, B16, 4'd1,  4'd2,  2'd0},  // R6 16-bit dest
        '{4'd6, KC, B8,  B8,  4'd3,  4'd4,  2'd0},  // R6 8-bit dest
        '{4'd5, KZ, B32, B8,  4'd9,  4'd10, 2'd1},  // R5 zext 8->32
        '{4'd5, KZ, B64, B16, 4'd9,  4'd10, 2'd0},  // R5 zext 16->64
        '{4'd5, KS, B64, B32, 4'd11, 4'd12, 2'd0},  // R5 sext
        '{4'd7, KC, B64, B64, 4'd13, 4'd13, 2'd0},  // R7 self copy
        '{4'd8, KX, B32, B32, 4'd2,  4'd2,  2'd2},  // R8 zeroing 32
        '{4'd8, KX, B16, B16, 4'd3,  4'd3,  2'd0},  // R8 narrow xor
        '{4'd8, KX, V2,  V2,  4'd4,  4'd4,  2'd2},  // R8 zeroing vector
        '{4'd2, KP, B64, B64, 4'd0,  4'd1,  2'd0},  // R2 plain op
        '{4'd9, KQ, V1,  V1,  4'd5,  4'd5,  2'd3},  // R9 ones idiom
        '{4'd6, KZ, B16, B8,  4'd6,  4'd7,  2'd0},  // R6 zext into 16-bit
        '{4'd3, KC, B32, B64, 4'd14, 4'd15, 2'd0}   // R3 width mismatch
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              elim_disable;
    logic [LN-1:0]     in_valid;
    logic [LN*3-1:0]   in_kind, in_dst_width, in_src_width;
    logic [LN*4-1:0]   in_dst, in_src1, in_src2;
    logic [LN*TW-1:0]  in_new_tag;
    logic [LN-1:0]     out_valid, out_elim, out_zero, out_src1_rdy, out_src2_rdy;
    logic [LN*TW-1:0]  out_dst_tag, out_src1_tag, out_src2_tag;

    move_elim i_move_elim (
        .clk, .rst_n, .elim_disable, .in_valid, .in_kind, .in_dst_width, .in_src_width,
        .in_dst, .in_src1, .in_src2, .in_new_tag, .out_valid, .out_elim, .out_zero,
        .out_dst_tag, .out_src1_tag, .out_src2_tag, .out_src1_rdy, .out_src2_rdy
    );

    int errors = 0;
    int checks = 0;
    int bmap [AR];
    int tagc = 20;

    logic       v  [LN];
    logic [2:0] k  [LN], dw [LN], sw [LN];
    logic [3:0] d  [LN], s1 [LN], s2 [LN];
    int         cl [LN];
    logic       dis;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    task automatic clear_lanes();
        for (int l = 0; l < LN; l++) begin
            v[l] = 1'b0; k[l] = KP; dw[l] = B64; sw[l] = B64;
            d[l] = 4'd0; s1[l] = 4'd0; s2[l] = 4'd0; cl[l] = 0;
        end
        dis = 1'b0;
    endtask

    task automatic set_lane(input int l, input logic [2:0] kk, input logic [2:0] ww, input logic [2:0] ss,
                            input logic [3:0] dd, input logic [3:0] a, input logic [3:0] b, input int c);
        v[l] = 1'b1; k[l] = kk; dw[l] = ww; sw[l] = ss;
        d[l] = dd; s1[l] = a; s2[l] = b; cl[l] = c;
    endtask

    // Present one group at a falling edge, then check the registered results one edge later
    task automatic go(input string rq);
        int tg [LN];
        for (int l = 0; l < LN; l++) begin
            tg[l] = tagc;
            tagc = (tagc >= 120) ? 20 : tagc + 1;
            in_valid[l]           = v[l];
            in_kind[l*3 +: 3]     = k[l];
            in_dst_width[l*3 +: 3] = dw[l];
            in_src_width[l*3 +: 3] = sw[l];
            in_dst[l*4 +: 4]      = d[l];
            in_src1[l*4 +: 4]     = s1[l];
            in_src2[l*4 +: 4]     = s2[l];
            in_new_tag[l*TW +: TW] = TW'(tg[l]);
        end
        elim_disable = dis;
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < LN; l++) begin
            logic [25:0] act, exp;
            int et1, et2, edt;
            logic er1, er2, eel, ez;
            act = {out_valid[l], out_elim[l], out_zero[l], out_src1_rdy[l], out_src2_rdy[l],
                   out_dst_tag[l*TW +: TW], out_src1_tag[l*TW +: TW], out_src2_tag[l*TW +: TW]};
            if (v[l]) begin
                et1 = bmap[s1[l]]; et2 = bmap[s2[l]];
                er1 = (et1 == 0); er2 = (et2 == 0);
                eel = 1'b0; ez = 1'b0; edt = tg[l];
                if (cl[l] == 1) begin
                    eel = 1'b1; edt = et1;
                end else if (cl[l] == 2) begin
                    eel = 1'b1; ez = 1'b1; edt = 0; et1 = 0; et2 = 0; er1 = 1'b1; er2 = 1'b1;
                end else if (cl[l] == 3) begin
                    et1 = 0; et2 = 0; er1 = 1'b1; er2 = 1'b1;
                end
                bmap[d[l]] = edt;
                exp = {1'b1, eel, ez, er1, er2, TW'(edt), TW'(et1), TW'(et2)};
                chk(act == exp, rq, $sformatf("lane %0d", l), 64'(act), 64'(exp));
            end else begin
                chk(out_valid[l] == 1'b0, rq, $sformatf("idle lane %0d", l), 64'(out_valid[l]), 64'd0);
            end
        end
        in_valid = '0;
        elim_disable = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        elim_disable = 1'b0; in_valid = '0; in_kind = '0; in_dst_width = '0; in_src_width = '0;
        in_dst = '0; in_src1 = '0; in_src2 = '0; in_new_tag = '0;
        for (int r = 0; r < AR; r++) bmap[r] = r + 1;
        repeat (3) @(negedge clk);
        // R1 outputs are zero in reset
        chk({out_valid, out_elim, out_zero, out_src1_rdy, out_src2_rdy} == '0, "R1", "flags in reset",
            64'({out_valid, out_elim, out_zero}), 64'd0);
        chk({out_dst_tag, out_src1_tag, out_src2_tag} == '0, "R1", "tags in reset",
            64'(out_dst_tag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset map r -> r+1
        clear_lanes();
        set_lane(0, KP, B64, B64, 4'd0, 4'd5, 4'd15, 0);
        go("R1");

        // Classification table, one op per group on lane 0
        for (int i = 0; i < NROW; i++) begin
            clear_lanes();
            set_lane(0, ROWS[i].k, ROWS[i].dw, ROWS[i].sw, ROWS[i].d, ROWS[i].s, ROWS[i].s, int'(ROWS[i].cl));
            go($sformatf("R%0d row %0d", ROWS[i].rq, i));
        end

        // R2 same register renamed by all five lanes, last wins
        clear_lanes();
        for (int l = 0; l < LN; l++) set_lane(l, KP, B64, B64, 4'd3, 4'd3, 4'd9, 0);
        go("R2");
        clear_lanes();
        set_lane(0, KC, B64, B64, 4'd3, 4'd12, 4'd12, 1);
        v[0] = 1'b0;                                   // R2 idle lane must not touch r3
        set_lane(1, KP, B64, B64, 4'd10, 4'd3, 4'd3, 0);
        go("R2");

        // R4 chained copies in one group, plus a self copy
        clear_lanes();
        set_lane(0, KC, B64, B64, 4'd1, 4'd2, 4'd2, 1);
        set_lane(1, KC, B64, B64, 4'd3, 4'd1, 4'd1, 1);
        set_lane(2, KZ, B64, B8,  4'd4, 4'd3, 4'd3, 1);
        set_lane(3, KP, B64, B64, 4'd5, 4'd4, 4'd4, 0);
        set_lane(4, KC, V2,  V2,  4'd4, 4'd4, 4'd4, 0); // R7 self copy in group
        go("R4");

        // R10 elimination off: copies renamed, zeroing idiom still removed
        clear_lanes();
        dis = 1'b1;
        set_lane(0, KC, B64, B64, 4'd1, 4'd2, 4'd2, 0);
        set_lane(1, KX, B32, B32, 4'd7, 4'd7, 4'd7, 2);
        set_lane(2, KZ, B32, B8,  4'd8, 4'd9, 4'd9, 0);
        go("R10");

        // R11 zero tag source readiness, also through a copy in the same group
        clear_lanes();
        set_lane(0, KX, V1,  V1,  4'd6, 4'd6, 4'd6, 2);
        set_lane(1, KP, B64, B64, 4'd11, 4'd6, 4'd8, 0);
        set_lane(2, KC, B64, B64, 4'd9, 4'd6, 4'd6, 1);
        set_lane(3, KQ, V2,  V2,  4'd12, 4'd12, 4'd12, 3); // R9 ones idiom
        go("R11");
        clear_lanes();
        set_lane(0, KP, B64, B64, 4'd13, 4'd9, 4'd6, 0);
        set_lane(4, KP, B64, B64, 4'd14, 4'd12, 4'd7, 0);
        go("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule